// File: doc/BRIEF.md
# Transmit Interframe Gap and Defer Gate

This block sits between a transmit sequencer and the medium interface. It decides the cycle in which a pending frame may raise transmit enable, and it records whether the first attempt of that frame had to wait for someone else's traffic. It watches receive-carrier activity and its own transmit-active state, and it runs a gap timer in clock cycles. The timer reloads whenever the medium is busy. When the medium goes quiet, it counts down from the programmed length for the case that applies: one length after a reception, another after its own transmission.

A start is granted only when the backoff count is zero, the transmit FIFO is not empty and the gap has run out. The decision is registered. Receive activity that shows up in the same cycle as the decision therefore cannot withdraw the start. The defer flag is raised on a first attempt in two cases: carrier activity is present while the frame waits, or the gap after a reception has not yet elapsed. The flag is held until the status writeback acknowledges it.

Top module: `txgap_defer_gate`

## Requirements
- R1: During and right after a synchronous reset, `tx_start` is 0, `defer` is 0 and `gap_done` is 1. After reset, the first gap is counted as following the block's own transmission.
- R2: A frame is ready in a cycle when `fifo_nonempty`=1, `backoff_zero`=1, `tx_active`=0 and `tx_start`=0. If `gap_done`=1 in that same cycle, `tx_start` is 1 for exactly the next cycle.
- R3: After a cycle with `tx_active`=1 and the medium then idle, `gap_done` rises on the `gap_tx2tx`-th clock edge after the first idle edge.
- R4: After a cycle with only `rx_active`=1 and the medium then idle, `gap_done` rises on the `gap_rx2tx`-th clock edge after the first idle edge.
- R5: Any activity sampled while the gap is counting restarts it from the full length, so `gap_done` is 0 in the cycle after any busy cycle.
- R6: A programmed gap length of 0 is treated as 1.
- R7: On a first attempt (`first_try`=1), a ready frame with `gap_done`=0 sets `defer` on the next edge if `rx_active`=1 or the running gap follows a reception.
- R8: Waiting only for a gap that follows the block's own transmission, with `rx_active`=0, does not set `defer`.
- R9: `rx_active` rising in the same cycle as a granted start decision (ready frame, `gap_done`=1) neither cancels the start nor sets `defer`.
- R10: While `first_try`=0, `defer` is never set.
- R11: `defer` stays 1 until a cycle with `defer_ack`=1 clears it on the next edge. A new defer condition in the ack cycle wins, and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_active | input | 1 | Receive carrier activity |
| tx_active | input | 1 | Own transmission in progress |
| fifo_nonempty | input | 1 | Transmit FIFO holds at least one byte |
| backoff_zero | input | 1 | Backoff count is zero |
| first_try | input | 1 | Current attempt is the frame's first |
| defer_ack | input | 1 | Status writeback has taken the defer flag |
| gap_rx2tx | input | GAP_W | Gap length in cycles after a reception |
| gap_tx2tx | input | GAP_W | Gap length in cycles after own transmission |
| tx_start | output | 1 | One-cycle start-transmit strobe |
| defer | output | 1 | First attempt had to defer |
| gap_done | output | 1 | Gap timer has expired |

## Verification
A wrong gap count or a wrong reload shows on `gap_done` within one cycle of the point where the expected countdown ends. It also delays or advances `tx_start` by the same amount. A mis-recorded gap case (after reception vs. after transmission) shows first at the ports as a wrong gap length. It then shows as a `defer` raised or missed on the next ready frame. The bench compares all three outputs on every clock against a behavioural model, so each such divergence is caught in the first cycle where the outputs differ.

// File: rtl/txgap_pkg.sv
package txgap_pkg;
    // Which event the currently running gap follows
    typedef enum logic {
        GAP_AFTER_TX = 1'b0,
        GAP_AFTER_RX = 1'b1
    } gap_kind_e;
endpackage

// File: rtl/txgap_timer.sv
// Gap timer: reloads while the medium is busy, counts down in clock cycles
// once it is idle, and remembers whether the gap follows a reception.
// Assumes the programmed lengths are stable while a gap is running.
module txgap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_active,
    input  logic             tx_active,
    input  logic [GAP_W-1:0] gap_rx2tx,
    input  logic [GAP_W-1:0] gap_tx2tx,
    output logic             expired,
    output logic             after_rx
);
    import txgap_pkg::*;

    localparam logic [GAP_W-1:0] ONE = GAP_W'(1);

    logic [GAP_W-1:0] remain;
    logic [GAP_W-1:0] sel_len;
    logic [GAP_W-1:0] load_len;
    gap_kind_e        kind;

    // Pick the length for the case in progress; zero is raised to one
    always_comb begin
        sel_len  = tx_active ? gap_tx2tx : gap_rx2tx;
        load_len = (sel_len == '0) ? ONE : sel_len;
    end

    // Reload while busy, otherwise count toward zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            kind   <= GAP_AFTER_TX;
        end else if (rx_active || tx_active) begin
            remain <= load_len;
            kind   <= tx_active ? GAP_AFTER_TX : GAP_AFTER_RX;
        end else if (remain != '0) begin
            remain <= remain - ONE;
        end
    end

    assign expired  = (remain == '0);
    assign after_rx = (kind == GAP_AFTER_RX);
endmodule

// File: rtl/txgap_start_gate.sv
// Start gate: grants a registered one-cycle start once a ready frame sees
// an expired gap. Assumes the sequencer raises tx_active after the strobe.
module txgap_start_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_nonempty,
    input  logic backoff_zero,
    input  logic tx_active,
    input  logic expired,
    output logic ready,
    output logic tx_start
);
    // A frame is waiting and no start is already in flight
    always_comb begin
        ready = fifo_nonempty && backoff_zero && !tx_active && !tx_start;
    end

    // Register the decision so late carrier cannot withdraw it
    always_ff @(posedge clk) begin
        if (!rst_n) tx_start <= 1'b0;
        else        tx_start <= ready && expired;
    end
endmodule

// File: rtl/txgap_defer_track.sv
// Defer tracker: records that a first attempt waited on foreign traffic
// or on the gap after a reception; held until acknowledged.
module txgap_defer_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    input  logic expired,
    input  logic rx_active,
    input  logic after_rx,
    input  logic first_try,
    input  logic defer_ack,
    output logic defer
);
    logic cause;

    // Waiting on the first attempt for carrier or a post-reception gap
    always_comb begin
        cause = ready && first_try && !expired && (rx_active || after_rx);
    end

    // Set has priority over the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)         defer <= 1'b0;
        else if (cause)     defer <= 1'b1;
        else if (defer_ack) defer <= 1'b0;
    end
endmodule

// File: rtl/txgap_defer_gate.sv
// Top: transmit interframe gap and defer gate. Joins the gap timer, the
// start gate and the defer tracker. All inputs are synchronous to clk.
module txgap_defer_gate #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_active,
    input  logic             tx_active,
    input  logic             fifo_nonempty,
    input  logic             backoff_zero,
    input  logic             first_try,
    input  logic             defer_ack,
    input  logic [GAP_W-1:0] gap_rx2tx,
    input  logic [GAP_W-1:0] gap_tx2tx,
    output logic             tx_start,
    output logic             defer,
    output logic             gap_done
);
    logic expired;
    logic after_rx;
    logic ready;

    txgap_timer #(.GAP_W(GAP_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_active (rx_active),
        .tx_active (tx_active),
        .gap_rx2tx (gap_rx2tx),
        .gap_tx2tx (gap_tx2tx),
        .expired   (expired),
        .after_rx  (after_rx)
    );

    txgap_start_gate gate_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_nonempty (fifo_nonempty),
        .backoff_zero  (backoff_zero),
        .tx_active     (tx_active),
        .expired       (expired),
        .ready         (ready),
        .tx_start      (tx_start)
    );

    txgap_defer_track defer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .expired   (expired),
        .rx_active (rx_active),
        .after_rx  (after_rx),
        .first_try (first_try),
        .defer_ack (defer_ack),
        .defer     (defer)
    );

    assign gap_done = expired;
endmodule

// File: rtl/txgap_defer_gate_chk.sv
// Checker for txgap_defer_gate: port-level properties, bound below.
module txgap_defer_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_active,
    input logic tx_active,
    input logic fifo_nonempty,
    input logic backoff_zero,
    input logic first_try,
    input logic defer_ack,
    input logic tx_start,
    input logic defer,
    input logic gap_done
);
    a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    a_r2_start_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_nonempty && backoff_zero && !tx_active && !tx_start && gap_done) |=> tx_start);

    a_r2_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_nonempty || !backoff_zero || tx_active || !gap_done) |=> !tx_start);

    a_r5_busy_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_active || tx_active) |=> !gap_done);

    a_r10_retry_no_defer: assert property (@(posedge clk) disable iff (!rst_n)
        (!defer && !first_try) |=> !defer);

    a_r11_defer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (defer && !defer_ack) |=> defer);

    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (defer && defer_ack && !first_try) |=> !defer);
endmodule

bind txgap_defer_gate txgap_defer_gate_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_active     (rx_active),
    .tx_active     (tx_active),
    .fifo_nonempty (fifo_nonempty),
    .backoff_zero  (backoff_zero),
    .first_try     (first_try),
    .defer_ack     (defer_ack),
    .tx_start      (tx_start),
    .defer         (defer),
    .gap_done      (gap_done)
);

// File: tb/txgap_defer_gate_tb.sv
module txgap_defer_gate_tb_top;
    localparam int GW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b0, tx = 1'b0, fifo = 1'b0, bz = 1'b1, first = 1'b1, ack = 1'b0;
    logic [GW-1:0] g_rt = 8'd6, g_tt = 8'd4;
    logic tx_start, defer, gap_done;

    int checks = 0, fails = 0, cycles = 0;
    string phase = "R1";

    // behavioural reference state
    int  m_left = 0;
    bit  m_rx_gap = 0, m_def = 0, m_go = 0;

    always #5 clk = ~clk;

    txgap_defer_gate #(.GAP_W(GW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_active(rx), .tx_active(tx),
        .fifo_nonempty(fifo), .backoff_zero(bz), .first_try(first),
        .defer_ack(ack), .gap_rx2tx(g_rt), .gap_tx2tx(g_tt),
        .tx_start(tx_start), .defer(defer), .gap_done(gap_done)
    );

    // Reference model, updated from the inputs seen at each rising edge
    always @(posedge clk) begin
        bit waiting, open_gap, cause;
        int len;
        cycles++;
        if (!rst_n) begin
            m_left = 0; m_rx_gap = 0; m_def = 0; m_go = 0;
        end else begin
            waiting  = fifo && bz && !tx && !m_go;
            open_gap = (m_left == 0);
            cause    = waiting && first && !open_gap && (rx || m_rx_gap);
            if (cause) m_def = 1; else if (ack) m_def = 0;
            m_go = waiting && open_gap;
            if (rx || tx) begin
                len = tx ? int'(g_tt) : int'(g_rt);
                m_left = (len < 1) ? 1 : len;
                m_rx_gap = !tx;
            end else if (m_left > 0) begin
                m_left--;
            end
        end
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", req, cycles, act, exp);
        end
    endtask

    // Compare every output on each falling edge, then let stimulus move
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk({phase, " tx_start"}, tx_start, m_go);
            chk({phase, " defer"}, defer, m_def);
            chk({phase, " gap_done"}, gap_done, m_left == 0);
        end
    endtask

    initial begin : watchdog
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        int rise_at;
        step(3);
        chk("R1 reset tx_start", tx_start, 1'b0);
        chk("R1 reset defer", defer, 1'b0);
        chk("R1 reset gap_done", gap_done, 1'b1);
        rst_n = 1'b1;
        step(2);

        // R4: length after reception, measured at the ports
        phase = "R4"; rx = 1; step(4); rx = 0;
        rise_at = 0;
        for (int i = 1; i <= 12; i++) begin step(1); if (gap_done && rise_at == 0) rise_at = i; end
        chk("R4 rx gap length", rise_at == 6, 1'b1);

        // R3: length after own transmission
        phase = "R3"; tx = 1; step(4); tx = 0;
        rise_at = 0;
        for (int i = 1; i <= 12; i++) begin step(1); if (gap_done && rise_at == 0) rise_at = i; end
        chk("R3 tx gap length", rise_at == 4, 1'b1);

        // R5: short pulse inside a running gap restarts it
        phase = "R5"; rx = 1; step(2); rx = 0; step(3); rx = 1; step(1); rx = 0; step(10);

        // R7: ready first attempt while carrier present, then gap after rx
        phase = "R7"; rx = 1; fifo = 1; step(3);
        chk("R7 defer under carrier", defer, 1'b1);
        rx = 0; step(9); fifo = 0; step(2);
        phase = "R11"; ack = 1; step(1); ack = 0; step(1);
        chk("R11 ack clears defer", defer, 1'b0);

        // R8: waiting only on transmit-to-transmit gap gives no defer
        phase = "R8"; tx = 1; step(3); tx = 0; fifo = 1; step(6); fifo = 0; step(2);
        chk("R8 no defer after own tx", defer, 1'b0);

        // R9: carrier appears in the decision cycle
        phase = "R9"; step(8); fifo = 1; rx = 1; step(1); fifo = 0;
        chk("R9 start survives late carrier", tx_start, 1'b1);
        step(3); rx = 0; step(8);
        chk("R9 no defer", defer, 1'b0);

        // R10: retries never flag defer
        phase = "R10"; first = 0; rx = 1; fifo = 1; step(4); rx = 0; step(8);
        chk("R10 retry no defer", defer, 1'b0);
        fifo = 0; first = 1; step(3);

        // R6: zero lengths act as one
        phase = "R6"; g_rt = 0; g_tt = 0; rx = 1; step(2); rx = 0; step(3);
        tx = 1; step(2); tx = 0; step(3);

        // R2 / R11: mixed random traffic
        phase = "R2 R11 random"; g_rt = 8'd5; g_tt = 8'd3;
        for (int i = 0; i < 3000; i++) begin
            rx    = ($urandom_range(0, 9) < 2);
            tx    = ($urandom_range(0, 9) < 1);
            fifo  = ($urandom_range(0, 9) < 6);
            bz    = ($urandom_range(0, 9) < 8);
            first = ($urandom_range(0, 9) < 7);
            ack   = ($urandom_range(0, 9) < 2);
            step(1);
        end
        rx = 0; tx = 0; fifo = 0; ack = 0; step(5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule